// File: doc/BRIEF.md
# EEPROM Page-Write Sequencer

This block is a host-side SPI master that copies a run of bytes into a 128-byte serial EEPROM. The user gives a 7-bit start address and a byte count and pulses `start`. The block pulls the bytes one at a time through a request/data pair. It cuts the job into bursts that never leave a 16-byte page. Each burst uses three kinds of chip-select frames. First comes a one-byte write-enable frame. Next comes a write frame that carries the opcode, the address and the data. Last come repeated status-read frames, sent until the busy flag reads clear.

SCK is made from the system clock by a parameterised divider. The bus runs in SPI mode 0: SCK idles low, the slave samples on the rising edge, and MOSI changes only while SCK is low. Every byte goes out MSb first. Between frames, CS stays high for at least `CS_GAP` clocks; `CS_GAP` must be 2 or more. The memory-side opcodes are fixed at 0x06 for write enable, 0x02 for write and 0x05 for status read. The status bit that means "write in progress" is bit 0 of the status byte.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, and busy, done and byte_req are all 0.
- R2: SCK is low whenever cs_n is high. MOSI changes only while SCK is low. Every byte is sent MSb first, so the slave reads the intended value on rising edges.
- R3: Each write frame comes right after a frame of its own that holds exactly 8 bits with the value 0x06. There is exactly one such frame per burst.
- R4: A write frame carries 0x02, then the address byte {1'b0, addr[6:0]}, then the data bytes. CS rises straight after the last bit of the last data byte, so the frame holds 8*(2+n) bits.
- R5: No burst crosses a 16-byte page. The first burst holds min(length, 16 - start_addr[3:0]) bytes and each later burst holds min(remaining, 16). Addresses advance modulo 128, so 0x7F is followed by 0x00.
- R6: After each write frame the block sends 16-bit status frames (0x05 followed by a dummy byte) and reads bit 0 of the second byte on MISO. It repeats these frames until that bit is 0. Only then does it send another write enable or write.
- R7: Between any two frames, cs_n stays high for at least CS_GAP clock cycles.
- R8: byte_req pulses once per data byte, in address order. byte_data is taken in the same cycle as the pulse. The bytes land in the memory at consecutive addresses.
- R9: busy is high from the cycle after an accepted start until done. done is a one-cycle pulse that falls in the cycle busy drops. It follows the status read that returns 0 after the final burst.
- R10: A start with length 0 raises done on the next clock edge, runs no SPI frame and leaves busy low.
- R11: A start pulse while busy is ignored. It does not change the job in progress and does not produce an extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job (taken only when idle) |
| start_addr | input | AW | First memory byte address |
| length | input | LW | Number of bytes to write |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse at job completion |
| byte_req | output | 1 | Next data byte is taken this cycle |
| byte_data | input | 8 | Data byte, valid while byte_req is high |
| sck | output | 1 | SPI clock, idles low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |

## Verification
Two decisions fall on the same clock edge: the last SCK fall of a byte and the frame decision. On that edge the block either loads the next data byte with a request or raises CS and moves to polling. The bench provokes this by starting jobs at the last byte of a page, at mid-page offsets and across the 0x7F to 0x00 wrap. Those starts put page ends at burst ends of 1, 2, 11, 13 and 16 bytes. A memory model on the bus records every frame's bit count and the burst lengths, then commits data. The bench judges the result against burst lengths it splits out from the requirements and against memory contents it predicts, bytes around the target included.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 4,
  parameter int AW      = 7,
  parameter int LW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] length,
  output logic          busy,
  output logic          done,
  output logic          byte_req,
  input  logic [7:0]    byte_data,
  output logic          sck,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  localparam int PW = 4;
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int GW = $clog2(CS_GAP + 1);
  localparam logic [PW:0] PAGE = (PW+1)'(1 << PW);
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_XFER} st_t;
  typedef enum logic [1:0] {F_WREN, F_WRITE, F_POLL} frm_t;

  st_t           st;
  frm_t          frm;
  logic [7:0]    sh, rx;
  logic [2:0]    bit_i;
  logic [1:0]    idx;
  logic          sck_r, cs_r, done_r;
  logic [DW-1:0] div;
  logic [GW-1:0] gap;
  logic [AW-1:0] addr;
  logic [LW-1:0] left;
  logic [PW:0]   burst;

  wire          tick     = (div == DW'(CLK_DIV - 1));
  wire          byte_end = (st == S_XFER) && tick && sck_r && (bit_i == 3'd7);
  wire [PW:0]   room     = PAGE - {1'b0, addr[PW-1:0]};
  wire [PW:0]   burst_n  = (left < LW'(room)) ? left[PW:0] : room;

  assign busy     = (st != S_IDLE);
  assign done     = done_r;
  assign sck      = sck_r;
  assign cs_n     = cs_r;
  assign mosi     = !cs_r && sh[7];
  assign byte_req = byte_end && (frm == F_WRITE) &&
                    ((idx == 2'd1) || (idx == 2'd2 && burst != (PW+1)'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; frm <= F_WREN;
      sh <= '0; rx <= '0; bit_i <= '0; idx <= '0;
      sck_r <= 1'b0; cs_r <= 1'b1; done_r <= 1'b0;
      div <= '0; gap <= '0; addr <= '0; left <= '0; burst <= '0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (length == '0) begin
              done_r <= 1'b1;
            end else begin
              addr <= start_addr;
              left <= length;
              frm  <= F_WREN;
              gap  <= '0;
              st   <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (gap == GW'(CS_GAP - 1)) begin
            st    <= S_XFER;
            cs_r  <= 1'b0;
            idx   <= '0;
            bit_i <= '0;
            div   <= '0;
            case (frm)
              F_WREN:  begin sh <= OP_WREN; burst <= burst_n; end
              F_WRITE: sh <= OP_WRITE;
              default: sh <= OP_RDSR;
            endcase
          end else begin
            gap <= gap + 1'b1;
          end
        end
        S_XFER: begin
          div <= tick ? '0 : div + 1'b1;
          if (tick) begin
            if (!sck_r) begin
              sck_r <= 1'b1;
              rx    <= {rx[6:0], miso};
            end else begin
              sck_r <= 1'b0;
              if (bit_i != 3'd7) begin
                bit_i <= bit_i + 1'b1;
                sh    <= {sh[6:0], 1'b0};
              end else begin
                bit_i <= '0;
                case (frm)
                  F_WREN: begin
                    cs_r <= 1'b1; gap <= '0; st <= S_GAP; frm <= F_WRITE;
                  end
                  F_WRITE: begin
                    if (idx == 2'd0) begin
                      sh  <= 8'(addr);
                      idx <= 2'd1;
                    end else if (idx == 2'd1) begin
                      sh  <= byte_data;
                      idx <= 2'd2;
                    end else begin
                      addr  <= addr + 1'b1;
                      left  <= left - 1'b1;
                      burst <= burst - 1'b1;
                      if (burst == (PW+1)'(1)) begin
                        cs_r <= 1'b1; gap <= '0; st <= S_GAP; frm <= F_POLL;
                      end else begin
                        sh <= byte_data;
                      end
                    end
                  end
                  default: begin
                    if (idx == 2'd0) begin
                      sh  <= 8'h00;
                      idx <= 2'd1;
                    end else begin
                      cs_r <= 1'b1;
                      gap  <= '0;
                      if (rx[0]) begin
                        st <= S_GAP; frm <= F_POLL;
                      end else if (left == '0) begin
                        st <= S_IDLE; done_r <= 1'b1;
                      end else begin
                        st <= S_GAP; frm <= F_WREN;
                      end
                    end
                  end
                endcase
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  a_r2_mosi_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sck);
  a_r7_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
  a_r5_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && frm == F_WRITE) |-> (burst != '0 && burst <= room));
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r8_req_framed: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |=> !cs_n);
endmodule

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;
  localparam int CLK_DIV = 2;
  localparam int CS_GAP  = 4;
  localparam int NPOLL   = 2;
  localparam int NV      = 6;
  localparam logic [14:0] VEC [NV] = '{
    {7'h00, 8'd1}, {7'h0E, 8'd5}, {7'h10, 8'd16},
    {7'h73, 8'd40}, {7'h05, 8'd48}, {7'h7F, 8'd2}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [6:0] start_addr = '0;
  logic [7:0] length = '0, byte_data;
  logic busy, done, byte_req, sck, cs_n, mosi, miso;

  always #4 clk = ~clk;

  eeprom_page_writer #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .length(length), .busy(busy), .done(done), .byte_req(byte_req),
    .byte_data(byte_data), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int total = 0, bad = 0, cyc = 0, job = 0, req_idx = 0;

  function automatic logic [7:0] pat(int j, int i);
    return 8'((i * 37 + j * 11 + 5) & 255);
  endfunction

  assign byte_data = pat(job, req_idx);
  always @(posedge clk) if (byte_req) req_idx <= req_idx + 1;

  logic [7:0] mem [128];
  logic [7:0] fb [32];
  logic [7:0] sr;
  int nbits = 0, wip_cnt = 0;
  logic wel = 0;
  int wr_frames, wren_frames, poll_frames, viol, nbl;
  int blen [16];
  assign miso = (!cs_n && nbits == 15) ? (wip_cnt > 0) : 1'b0;

  always @(negedge cs_n) nbits = 0;
  always @(posedge sck) if (!cs_n) begin
    sr = {sr[6:0], mosi};
    nbits = nbits + 1;
    if (nbits % 8 == 0 && nbits <= 256) fb[nbits/8 - 1] = sr;
  end
  always @(posedge cs_n) begin
    if (nbits > 0) begin
      if (fb[0] == 8'h06) begin
        wren_frames++;
        if (nbits != 8 || wip_cnt > 0) viol++;
        if (nbits == 8) wel = 1;
      end else if (fb[0] == 8'h02) begin
        int n, a;
        wr_frames++;
        n = nbits / 8 - 2;
        a = fb[1];
        if (!wel || wip_cnt > 0 || nbits % 8 != 0 || n < 1 || a > 127) viol++;
        if (n > 16 || (a % 16) + n > 16) viol++;
        if (nbl < 16) blen[nbl] = n;
        nbl++;
        for (int i = 0; i < n && i < 30; i++)
          mem[(a & 8'h70) | ((a + i) & 15)] = fb[2 + i];
        wel = 0;
        wip_cnt = NPOLL;
      end else if (fb[0] == 8'h05) begin
        poll_frames++;
        if (nbits != 16) viol++;
        if (wip_cnt > 0) wip_cnt--;
      end else viol++;
    end
  end

  int done_cnt = 0, early_done = 0, mosi_bad = 0, hi_run = 0, min_gap = 1000;
  logic mosi_q = 0, cs_q = 1;
  always @(negedge clk) begin
    if (done) begin
      done_cnt++;
      if (wip_cnt != 0 || busy) early_done++;
    end
    if (!cs_n && mosi != mosi_q && sck) mosi_bad++;
    if (cs_n) hi_run++;
    else if (cs_q && hi_run < min_gap) min_gap = hi_run;
    if (!cs_n) hi_run = 0;
    mosi_q = mosi;
    cs_q = cs_n;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    wr_frames = 0; wren_frames = 0; poll_frames = 0; viol = 0; nbl = 0;
    done_cnt = 0; early_done = 0; mosi_bad = 0; min_gap = 1000;
    req_idx = 0;
    for (int i = 0; i < 128; i++) mem[i] = 8'hEE;
  endtask

  task automatic pulse_start(input logic [6:0] a, input logic [7:0] l);
    @(negedge clk);
    start_addr = a; length = l; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_job(input logic [6:0] a, input logic [7:0] l, input bit interfere);
    int ea, el, nb, mism, untouched;
    int eb [16];
    clear_log();
    job++;
    ea = a; el = l; nb = 0;
    while (el > 0) begin
      int b;
      b = (el < 16 - ea % 16) ? el : 16 - ea % 16;
      if (nb < 16) eb[nb] = b;
      nb++; el -= b; ea = (ea + b) % 128;
    end
    pulse_start(a, l);
    chk(busy == 1, "R9 busy after start", busy, 1);
    if (interfere) begin
      repeat (300) @(negedge clk);
      pulse_start(7'h60, 8'd3);
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(done_cnt == 1, "R9 done pulses", done_cnt, 1);
    chk(early_done == 0, "R6 done only after WIP clear", early_done, 0);
    chk(wr_frames == nb, "R5 burst count", wr_frames, nb);
    chk(wren_frames == nb, "R3 one WREN per burst", wren_frames, nb);
    chk(poll_frames == nb * (NPOLL + 1), "R6 status polls", poll_frames, nb * (NPOLL + 1));
    chk(viol == 0, "R4 frame format/order", viol, 0);
    mism = 0;
    for (int i = 0; i < nb && i < 16; i++) if (blen[i] != eb[i]) mism++;
    chk(mism == 0, "R5 burst lengths", mism, 0);
    chk(req_idx == l, "R8 byte requests", req_idx, l);
    mism = 0;
    for (int i = 0; i < l; i++) if (mem[(a + i) % 128] != pat(job, i)) mism++;
    chk(mism == 0, "R8 memory contents", mism, 0);
    untouched = (mem[(a + 127) % 128] == 8'hEE) && (mem[(a + l) % 128] == 8'hEE);
    chk(l >= 127 || untouched, "R5 neighbours untouched", untouched, 1);
    chk(min_gap >= CS_GAP, "R7 CS high gap", min_gap, CS_GAP);
    chk(mosi_bad == 0, "R2 MOSI stable while SCK high", mosi_bad, 0);
    if (interfere) begin
      chk(mem[7'h60] == 8'hEE && mem[7'h62] == 8'hEE, "R11 start ignored while busy",
          mem[7'h60], 8'hEE);
    end
  endtask

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sck == 0, "R1 bus idle in reset", {cs_n, sck}, 2);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && byte_req == 0, "R1 flags after reset",
        {busy, done, byte_req}, 0);
    chk(cs_n == 1 && sck == 0, "R2 SCK low while CS high", {cs_n, sck}, 2);

    for (int v = 0; v < NV; v++) run_job(VEC[v][14:8], VEC[v][7:0], 1'b0);

    run_job(7'h20, 8'd4, 1'b1);

    clear_log();
    @(negedge clk);
    start_addr = 7'h33; length = 8'd0; start = 1;
    @(negedge clk);
    start = 0;
    chk(done == 1 && busy == 0, "R10 zero-length done next edge", {done, busy}, 2);
    repeat (200) @(negedge clk);
    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    chk(wr_frames + wren_frames + poll_frames == 0, "R10 no frames",
        wr_frames + wren_frames + poll_frames, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule